// File: doc/BRIEF.md
# Dual-Axis Triangle Dither Generator

This block produces two signed triangle-wave dither words, one for the pitch sensing path and one for the volume sensing path. A single up/down level counter, clocked from the fast system clock, traces a unit triangle. The triangle starts at zero, climbs to a peak of `QUARTER`, falls to `-QUARTER`, and climbs back toward zero, for a period of `4*QUARTER` clock cycles. Each sample strobe forces the counter back to level zero in its rising state. When the strobe arrives once per period, the dither stays phase-locked to axis sampling, and a whole period of dither cancels within every sample.

Each axis scales the unit triangle by its own power-of-two shift code. Code 0 turns that axis's dither off. Code c from 1 upward shifts the triangle left by c-1. The volume axis always receives the negated scaled triangle, so when both codes are equal the two axes dither in opposite directions.

Top module: `dual_dither`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the unit level is 0 and counting up, so both outputs are 0.
- R2: With no strobe, the unit level changes by exactly +1 or -1 every cycle. It reaches +QUARTER at phase QUARTER and -QUARTER at phase 3*QUARTER. Phase is the number of cycles since the last restart. The level at phase k is k for k<=QUARTER, 2*QUARTER-k for k<=3*QUARTER, and k-4*QUARTER otherwise.
- R3: A strobe sampled at any clock edge, including one in the middle of a period, makes the unit level 0 and rising in the following cycle, which is phase 0.
- R4: The pitch output equals the unit level times 2^(c-1) when its code c is 1 to 7. It follows a change of code in the same cycle.
- R5: A pitch or volume code of 0 holds that output at 0, whatever the level.
- R6: The volume output equals minus the unit level times 2^(v-1) for volume code v from 1 to 7.
- R7: With a constant code, the sum of either output over the 4*QUARTER cycles of phases 0 to 4*QUARTER-1 is zero.
- R8: Whenever the two codes are equal, the pitch and volume outputs sum to zero.
- R9: Without strobes, the triangle keeps running with period 4*QUARTER. After phase 4*QUARTER-1 the level returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Axis sample strobe; restarts the triangle at phase 0 |
| pitch_shift | input | SHIFT_W | Pitch amplitude code (0 = off, c = shift by c-1) |
| vol_shift | input | SHIFT_W | Volume amplitude code (0 = off, v = shift by v-1) |
| pitch_dither | output | OUT_W | Signed pitch dither word |
| vol_dither | output | OUT_W | Signed volume dither word, inverted polarity |

## Verification
The unit level is the only register. A strobe or a step of the triangle sampled at one rising edge shows up on the outputs right after that edge. The shift codes reach the outputs through logic alone, in the same cycle they change. The bench therefore drives strobe and codes at the falling edge and advances its own phase model at the next rising edge. It compares both outputs against that model at the following falling edge, which covers the registered path and the combinational code path in one check. The zero-sum check adds up the falling-edge samples of one whole period, phases 0 through 4*QUARTER-1, and counts that period only if its code stayed constant throughout.

// File: rtl/dual_dither.sv
module dual_dither #(
  parameter int QUARTER = 16,
  parameter int SHIFT_W = 3,
  localparam int TRI_W = $clog2(QUARTER + 1) + 1,
  localparam int MAX_SH = (1 << SHIFT_W) - 2,
  localparam int OUT_W = TRI_W + MAX_SH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_stb,
  input  logic [SHIFT_W-1:0]       pitch_shift,
  input  logic [SHIFT_W-1:0]       vol_shift,
  output logic signed [OUT_W-1:0]  pitch_dither,
  output logic signed [OUT_W-1:0]  vol_dither
);

  localparam logic signed [TRI_W-1:0] TOP = TRI_W'(QUARTER);
  localparam logic signed [TRI_W-1:0] BOT = -TOP;
  localparam logic signed [TRI_W-1:0] ONE = TRI_W'(1);

  logic signed [TRI_W-1:0] lvl;
  logic                    up;
  logic signed [OUT_W-1:0] wide;

  always_ff @(posedge clk) begin
    if (rst || sample_stb) begin
      lvl <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (lvl == TOP) begin
        lvl <= TOP - ONE;
        up  <= 1'b0;
      end else begin
        lvl <= lvl + ONE;
      end
    end else begin
      if (lvl == BOT) begin
        lvl <= BOT + ONE;
        up  <= 1'b1;
      end else begin
        lvl <= lvl - ONE;
      end
    end
  end

  assign wide = {{(OUT_W-TRI_W){lvl[TRI_W-1]}}, lvl};

  function automatic logic signed [OUT_W-1:0] scale(input logic signed [OUT_W-1:0] v,
                                                    input logic [SHIFT_W-1:0] c);
    if (c == '0) return '0;
    return v <<< (c - 1'b1);
  endfunction

  assign pitch_dither = scale(wide, pitch_shift);
  assign vol_dither   = -scale(wide, vol_shift);

  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> ((lvl - $past(lvl) == ONE) || ($past(lvl) - lvl == ONE)));

  p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (lvl <= TOP) && (lvl >= BOT));

  p_peak_turn_r2: assert property (@(posedge clk) disable iff (rst)
    (up && lvl == TOP && !sample_stb) |=> (!up && lvl == TOP - ONE));

  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> (lvl == '0 && up));

  p_opposite_r8: assert property (@(posedge clk) disable iff (rst)
    (pitch_shift == vol_shift) |-> (pitch_dither + vol_dither == '0));

endmodule

// File: tb/dual_dither_test.sv
module dual_dither_test;
  localparam int Q = 16;
  localparam int SW = 3;
  localparam int P = 4 * Q;
  localparam int OW = ($clog2(Q + 1) + 1) + ((1 << SW) - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic [SW-1:0] pc = '0;
  logic [SW-1:0] vc = '0;
  logic signed [OW-1:0] pd, vd;

  int total = 0, bad = 0;
  int ph = 0;
  int acc = 0;
  bit clean = 0;
  logic [SW-1:0] pc0;

  always #5 clk = ~clk;

  dual_dither #(.QUARTER(Q), .SHIFT_W(SW)) uut (
    .clk(clk), .rst(rst), .sample_stb(stb),
    .pitch_shift(pc), .vol_shift(vc),
    .pitch_dither(pd), .vol_dither(vd));

  function automatic int unit_at(int k);
    if (k <= Q) return k;
    if (k <= 3 * Q) return 2 * Q - k;
    return k - 4 * Q;
  endfunction

  function automatic int sc(int u, int c);
    if (c == 0) return 0;
    return u * (1 << (c - 1));
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (phase %0d pc=%0d vc=%0d)", req, act, exp, ph, pc, vc);
    end
  endtask

  // one clock: model update at rising edge, checks at falling edge
  task automatic cyc();
    @(posedge clk);
    if (rst || stb) ph = 0; else ph = (ph + 1) % P;
    @(negedge clk);
    if (!rst) begin
      chk((pc == 0) ? "R5 pitch off" : "R2/R4 pitch", int'(pd), sc(unit_at(ph), pc));
      chk((vc == 0) ? "R5 vol off" : "R6 vol", int'(vd), -sc(unit_at(ph), vc));
      if (pc == vc) chk("R8 opposite sum", int'(pd) + int'(vd), 0);
      if (ph == 0) begin acc = int'(pd); clean = 1; pc0 = pc; end
      else begin
        acc += int'(pd);
        if (pc != pc0) clean = 0;
      end
      if (ph == P - 1 && clean) chk("R7 period sum", acc, 0);
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    pc = 3'd7; vc = 3'd7;
    repeat (3) @(negedge clk);
    chk("R1 reset pitch", int'(pd), 0);
    chk("R1 reset vol", int'(vd), 0);
    @(negedge clk);
    rst = 1'b0; pc = 3'd1; vc = 3'd1;
    #1 chk("R1 first cycle", int'(pd), 0);
    // R2/R7/R8: locked strobes, unit amplitude
    for (int n = 0; n < 3 * P; n++) begin
      stb = (ph == P - 1);
      cyc();
      if (ph == Q) chk("R2 peak", int'(pd), Q);
      if (ph == 3 * Q) chk("R2 trough", int'(pd), -Q);
    end
    stb = 0;
    // R4 code change in same cycle
    pc = 3'd5;
    #1 chk("R4 same-cycle code", int'(pd), sc(unit_at(ph), 5));
    // R5 code 0
    pc = 3'd0; vc = 3'd4;
    repeat (20) cyc();
    // R3 mid-period restart
    pc = 3'd2; vc = 3'd2;
    repeat (7) cyc();
    stb = 1; cyc(); stb = 0;
    chk("R3 restart level", int'(pd), 0);
    cyc();
    chk("R3 rising after restart", int'(pd), 2);
    // R9 free-run across several periods
    pc = 3'd3; vc = 3'd6;
    repeat (3 * P + 5) cyc();
    // random: codes changed at period starts, occasional early strobes
    for (int n = 0; n < 4000; n++) begin
      stb = (ph == P - 1) || ($urandom_range(0, 199) == 0);
      if (ph == P - 1 || stb) begin
        pc = SW'($urandom_range(0, 7));
        vc = ($urandom_range(0, 3) == 0) ? pc : SW'($urandom_range(0, 7));
      end
      cyc();
    end
    stb = 0;
    // extreme codes
    pc = 3'd7; vc = 3'd7;
    repeat (P + 3) cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule